// File: doc/BRIEF.md
# Set-Associative Translation Lookup Buffer

This block translates a 32-bit virtual address into a physical address for a software-managed, set-associative translation buffer. Memory is split into 4 KB pages. The upper twenty address bits form the page number. The low bits of that page number select one set. Every way of that set is compared against the request at the same time. A way matches when its stored page number equals the request's page number and one of two things is true: the entry is marked global, or its stored process identifier equals the current one. A per-entry valid flag is kept in the tag word, but the match logic never looks at it.

The result is produced combinationally and is also registered one cycle later, together with a strobe. When several ways match, the lowest-numbered way wins. The registered result carries the physical address and four attribute bits: readable, writable, executable and cacheable. The page offset passes through unchanged. The entries live inside the block. A simple write port, driven by a maintenance unit or a test, loads one set and way per cycle.

Top module: `tlbx_lookup`

## Requirements
- R1: The page number is `req_vaddr[31:12]`, the set index is the low `log2(ENTRIES/WAYS)` bits of the page number, and on a hit the physical address keeps `req_vaddr[11:0]` in its bits 11:0.
- R2: A tag word holds the page number in bits 31:12, the global flag in bit 11, the valid flag in bit 10 and the process identifier in bits `PID_W-1:0`.
- R3: A way hits only when its tag page number equals the request page number, and either its global flag is 1 or its stored identifier equals `req_pid`. A mismatch in either part gives no hit from that way.
- R4: The valid flag, tag bit 10, has no effect on the result. An entry with that bit at 0 hits exactly as it would with the bit at 1.
- R5: When more than one way of the set hits, the lowest-numbered hitting way supplies the translation.
- R6: A data word holds the frame number in bits 19:0, cacheable in bit 20, readable in bit 21, writable in bit 22 and executable in bit 23. On a hit the physical address is `{frame, req_vaddr[11:0]}` and each attribute output copies its data bit.
- R7: On a miss the hit flag is 0, the physical address is 0 and all four attribute outputs are 0.
- R8: `cmb_hit` and `cmb_paddr` follow the inputs in the same cycle. The clock edge at which `req_vld` is 1 loads the result into the `rsp_*` outputs and raises `rsp_vld`. After an edge with `req_vld` at 0, `rsp_vld` is 0.
- R9: Synchronous reset clears every tag and data word to zero. As a consequence, a lookup in page 0 with identifier 0 hits, with physical address equal to the offset and no attributes, while any other identifier misses there.
- R10: One write updates one set and way at the clock edge. A lookup in the same cycle as that write sees the old contents, and lookups from the next cycle on see the new contents.
- R11: An entry is found only through the set it was written into. A matching tag stored in a set other than the one the request's page number selects never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Lookup request; its result is registered at this edge |
| req_vaddr | input | 32 | Virtual address to translate |
| req_pid | input | PID_W | Current process identifier |
| wr_en | input | 1 | Write one entry at this edge |
| wr_set | input | log2(ENTRIES/WAYS) | Set to write |
| wr_way | input | log2(WAYS) | Way to write |
| wr_tag | input | 32 | Tag word, layout per R2 |
| wr_data | input | 24 | Data word, layout per R6 |
| cmb_hit | output | 1 | Combinational hit |
| cmb_paddr | output | 32 | Combinational physical address |
| rsp_vld | output | 1 | Registered result strobe |
| rsp_hit | output | 1 | Registered hit |
| rsp_paddr | output | 32 | Registered physical address |
| rsp_rd | output | 1 | Registered readable attribute |
| rsp_wr | output | 1 | Registered writable attribute |
| rsp_ex | output | 1 | Registered executable attribute |
| rsp_cache | output | 1 | Registered cacheable attribute |

## Verification
The bench builds the block with its defaults: 4 ways, 64 entries (16 sets) and an 8-bit identifier. Four ways are enough to load three matching ways into one set, so the bench can show that the lowest way wins even when that way holds a global entry and a higher way holds an exact identifier match. Sixteen sets give room to place a correct tag in the wrong set, and the all-zero reset state makes page 0 hit with identifier 0.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int PAGE_W   = 12;
    localparam int VPN_W    = 32 - PAGE_W;
    localparam int PFN_W    = 20;
    localparam int TAG_W    = 32;
    localparam int DATA_W   = PFN_W + 4;
    localparam int TAG_GLB  = 11;

    typedef struct packed {
        logic             ex;
        logic             wr;
        logic             rd;
        logic             cache;
        logic [PFN_W-1:0] pfn;
    } tlb_data_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
        logic cache;
    } perm_t;

    typedef struct packed {
        logic        hit;
        logic [31:0] paddr;
        perm_t       perm;
    } xlat_t;

    function automatic logic [VPN_W-1:0] tag_vpn(input logic [TAG_W-1:0] t);
        return t[TAG_W-1:PAGE_W];
    endfunction

    function automatic perm_t perm_of(input tlb_data_t d);
        perm_t p;
        p.rd    = d.rd;
        p.wr    = d.wr;
        p.ex    = d.ex;
        p.cache = d.cache;
        return p;
    endfunction

endpackage

// File: rtl/tlbx_store.sv
module tlbx_store
    import tlbx_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int SET_W = 4,
    parameter int WAY_W = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [SET_W-1:0]            wr_set,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [TAG_W-1:0]            wr_tag,
    input  tlb_data_t                   wr_data,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
    output tlb_data_t [WAYS-1:0]        rd_data
);

    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    tlb_data_t        data_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]  <= '0;
                    data_q[s][w] <= '0;
                end
            end
        end else if (wr_en) begin
            tag_q[wr_set][wr_way]  <= wr_tag;
            data_q[wr_set][wr_way] <= wr_data;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_tags[w] = tag_q[rd_set][w];
        assign rd_data[w] = data_q[rd_set][w];
    end

endmodule

// File: rtl/tlbx_match.sv
module tlbx_match
    import tlbx_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int PID_W = 8
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [VPN_W-1:0]           req_vpn,
    input  logic [PID_W-1:0]           req_pid,
    output logic [WAYS-1:0]            hit_vec
);

    // The valid flag (bit 10) and the spare bits between it and the PID field
    // are left out of the compare on purpose.
    logic unused_tag_bits;
    assign unused_tag_bits = ^tags;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic vpn_eq;
        logic pid_ok;
        assign vpn_eq     = (tag_vpn(tags[w]) == req_vpn);
        assign pid_ok     = tags[w][TAG_GLB] || (tags[w][PID_W-1:0] == req_pid);
        assign hit_vec[w] = vpn_eq && pid_ok;
    end

endmodule

// File: rtl/tlbx_select.sv
module tlbx_select
    import tlbx_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  logic [WAYS-1:0]      hit_vec,
    input  tlb_data_t [WAYS-1:0] data,
    input  logic [PAGE_W-1:0]    offset,
    output xlat_t                xlat
);

    always_comb begin
        xlat = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w] && !xlat.hit) begin
                xlat.hit   = 1'b1;
                xlat.paddr = {data[w].pfn, offset};
                xlat.perm  = perm_of(data[w]);
            end
        end
    end

endmodule

// File: rtl/tlbx_lookup.sv
module tlbx_lookup
    import tlbx_pkg::*;
#(
    parameter int WAYS    = 4,
    parameter int ENTRIES = 64,
    parameter int PID_W   = 8,
    localparam int SETS   = ENTRIES / WAYS,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic [31:0]       req_vaddr,
    input  logic [PID_W-1:0]  req_pid,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [31:0]       wr_tag,
    input  logic [23:0]       wr_data,
    output logic              cmb_hit,
    output logic [31:0]       cmb_paddr,
    output logic              rsp_vld,
    output logic              rsp_hit,
    output logic [31:0]       rsp_paddr,
    output logic              rsp_rd,
    output logic              rsp_wr,
    output logic              rsp_ex,
    output logic              rsp_cache
);

    logic [VPN_W-1:0]           vpn;
    logic [SET_W-1:0]           set_idx;
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    tlb_data_t [WAYS-1:0]       set_data;
    logic [WAYS-1:0]            hit_vec;
    xlat_t                      xlat_now;
    xlat_t                      xlat_q;
    logic                       vld_q;

    assign vpn     = req_vaddr[31:PAGE_W];
    assign set_idx = vpn[SET_W-1:0];

    tlbx_store #(.WAYS(WAYS), .SETS(SETS), .SET_W(SET_W), .WAY_W(WAY_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_set  (wr_set),
        .wr_way  (wr_way),
        .wr_tag  (wr_tag),
        .wr_data (tlb_data_t'(wr_data)),
        .rd_set  (set_idx),
        .rd_tags (set_tags),
        .rd_data (set_data)
    );

    tlbx_match #(.WAYS(WAYS), .PID_W(PID_W)) u_match (
        .tags    (set_tags),
        .req_vpn (vpn),
        .req_pid (req_pid),
        .hit_vec (hit_vec)
    );

    tlbx_select #(.WAYS(WAYS)) u_select (
        .hit_vec (hit_vec),
        .data    (set_data),
        .offset  (req_vaddr[PAGE_W-1:0]),
        .xlat    (xlat_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            xlat_q <= '0;
        end else begin
            vld_q <= req_vld;
            if (req_vld) begin
                xlat_q <= xlat_now;
            end
        end
    end

    assign cmb_hit   = xlat_now.hit;
    assign cmb_paddr = xlat_now.paddr;
    assign rsp_vld   = vld_q;
    assign rsp_hit   = xlat_q.hit;
    assign rsp_paddr = xlat_q.paddr;
    assign rsp_rd    = xlat_q.perm.rd;
    assign rsp_wr    = xlat_q.perm.wr;
    assign rsp_ex    = xlat_q.perm.ex;
    assign rsp_cache = xlat_q.perm.cache;

endmodule

// File: rtl/tlbx_lookup_chk.sv
module tlbx_lookup_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_vld,
    input logic [31:0] req_vaddr,
    input logic        cmb_hit,
    input logic [31:0] cmb_paddr,
    input logic        rsp_vld,
    input logic        rsp_hit,
    input logic [31:0] rsp_paddr,
    input logic        rsp_rd,
    input logic        rsp_wr,
    input logic        rsp_ex,
    input logic        rsp_cache
);

    assert_rsp_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> rsp_vld);

    assert_rsp_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> !rsp_vld);

    assert_rsp_hit_follows_R8: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> (rsp_hit == $past(cmb_hit)));

    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (rst)
        cmb_hit |-> (cmb_paddr[11:0] == req_vaddr[11:0]));

    assert_cmb_miss_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !cmb_hit |-> (cmb_paddr == 32'h0));

    assert_rsp_miss_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && !rsp_hit) |->
            (rsp_paddr == 32'h0 && !rsp_rd && !rsp_wr && !rsp_ex && !rsp_cache));

endmodule

bind tlbx_lookup tlbx_lookup_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_vld   (req_vld),
    .req_vaddr (req_vaddr),
    .cmb_hit   (cmb_hit),
    .cmb_paddr (cmb_paddr),
    .rsp_vld   (rsp_vld),
    .rsp_hit   (rsp_hit),
    .rsp_paddr (rsp_paddr),
    .rsp_rd    (rsp_rd),
    .rsp_wr    (rsp_wr),
    .rsp_ex    (rsp_ex),
    .rsp_cache (rsp_cache)
);

// File: tb/tlbx_lookup_bench.sv
module tlbx_lookup_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WAYS    = 4;
    localparam int ENTRIES = 64;
    localparam int PID_W   = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [7:0]  req_pid = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_set = '0;
    logic [1:0]  wr_way = '0;
    logic [31:0] wr_tag = '0;
    logic [23:0] wr_data = '0;
    logic        cmb_hit, rsp_vld, rsp_hit, rsp_rd, rsp_wr, rsp_ex, rsp_cache;
    logic [31:0] cmb_paddr, rsp_paddr;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlbx_lookup #(.WAYS(WAYS), .ENTRIES(ENTRIES), .PID_W(PID_W)) u_tlbx_lookup (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_vaddr(req_vaddr),
        .req_pid(req_pid), .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way),
        .wr_tag(wr_tag), .wr_data(wr_data), .cmb_hit(cmb_hit),
        .cmb_paddr(cmb_paddr), .rsp_vld(rsp_vld), .rsp_hit(rsp_hit),
        .rsp_paddr(rsp_paddr), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
        .rsp_ex(rsp_ex), .rsp_cache(rsp_cache)
    );

    function automatic logic [31:0] mk_tag(input logic [19:0] vpn, input bit g,
                                           input bit v, input logic [7:0] pid);
        return {vpn, g, v, 2'b00, pid};
    endfunction

    // perms given as {rd, wr, ex, cache}
    function automatic logic [23:0] mk_data(input logic [19:0] pfn, input logic [3:0] p);
        return {p[1], p[2], p[3], p[0], pfn};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic put(input logic [3:0] s, input logic [1:0] w,
                       input logic [31:0] t, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_set = s; wr_way = w; wr_tag = t; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] pid, input bit eh,
                        input logic [31:0] epa, input logic [3:0] ep, input string rq);
        logic [3:0] ap;
        @(negedge clk);
        req_vld = 1'b1; req_vaddr = va; req_pid = pid;
        #1;
        chk(cmb_hit == eh, rq, "cmb_hit", 32'(cmb_hit), 32'(eh));
        chk(cmb_paddr == epa, rq, "cmb_paddr", cmb_paddr, epa);
        @(posedge clk);
        #1;
        req_vld = 1'b0;
        ap = {rsp_rd, rsp_wr, rsp_ex, rsp_cache};
        chk(rsp_vld == 1'b1, rq, "rsp_vld", 32'(rsp_vld), 32'd1);
        chk(rsp_hit == eh, rq, "rsp_hit", 32'(rsp_hit), 32'(eh));
        chk(rsp_paddr == epa, rq, "rsp_paddr", rsp_paddr, epa);
        chk(ap == ep, rq, "rsp_perm", 32'(ap), 32'(ep));
    endtask

    task automatic t_reset_r9;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk(rsp_vld == 1'b0, "R8", "rsp_vld after reset", 32'(rsp_vld), 0);
        chk(rsp_hit == 1'b0, "R9", "rsp_hit after reset", 32'(rsp_hit), 0);
        look(32'h0000_0123, 8'h00, 1'b1, 32'h0000_0123, 4'b0000, "R9");
        look(32'h0000_0123, 8'h05, 1'b0, 32'h0, 4'b0000, "R9");
    endtask

    task automatic t_basic_r3_r6;
        put(4'd5, 2'd1, mk_tag(20'h12345, 0, 1, 8'h2A), mk_data(20'hABCDE, 4'b1101));
        look(32'h1234_5678, 8'h2A, 1'b1, 32'hABCD_E678, 4'b1101, "R6");
        look(32'h1234_5678, 8'h2B, 1'b0, 32'h0, 4'b0000, "R3");
        look(32'h1234_6678, 8'h2A, 1'b0, 32'h0, 4'b0000, "R7");
    endtask

    task automatic t_global_r3;
        put(4'd6, 2'd2, mk_tag(20'h00016, 1, 1, 8'h11), mk_data(20'h00777, 4'b1010));
        look(32'h0001_6ABC, 8'h99, 1'b1, 32'h0077_7ABC, 4'b1010, "R3");
        look(32'h0001_6001, 8'h11, 1'b1, 32'h0077_7001, 4'b1010, "R2");
    endtask

    task automatic t_valid_ignored_r4;
        put(4'd7, 2'd0, mk_tag(20'h40007, 0, 0, 8'h03), mk_data(20'h55555, 4'b0100));
        look(32'h4000_7FFF, 8'h03, 1'b1, 32'h5555_5FFF, 4'b0100, "R4");
    endtask

    task automatic t_priority_r5;
        put(4'd9, 2'd3, mk_tag(20'h00009, 0, 1, 8'h01), mk_data(20'h33333, 4'b1000));
        look(32'h0000_9010, 8'h01, 1'b1, 32'h3333_3010, 4'b1000, "R5");
        put(4'd9, 2'd2, mk_tag(20'h00009, 0, 1, 8'h02), mk_data(20'h22222, 4'b0100));
        put(4'd9, 2'd1, mk_tag(20'h00009, 1, 1, 8'h07), mk_data(20'h11111, 4'b0010));
        look(32'h0000_9020, 8'h01, 1'b1, 32'h1111_1020, 4'b0010, "R5");
        look(32'h0000_9030, 8'h02, 1'b1, 32'h1111_1030, 4'b0010, "R5");
    endtask

    task automatic t_wrong_set_r11;
        put(4'd3, 2'd0, mk_tag(20'h12345, 1, 1, 8'h01), mk_data(20'hFFFFF, 4'b1111));
        look(32'h1234_5000, 8'h01, 1'b0, 32'h0, 4'b0000, "R11");
    endtask

    task automatic t_same_cycle_r10;
        @(negedge clk);
        wr_en = 1'b1; wr_set = 4'd10; wr_way = 2'd0;
        wr_tag = mk_tag(20'h0000A, 0, 1, 8'h04); wr_data = mk_data(20'h0BEEF, 4'b1001);
        req_vld = 1'b1; req_vaddr = 32'h0000_A010; req_pid = 8'h04;
        #1;
        chk(cmb_hit == 1'b0, "R10", "cmb_hit during write", 32'(cmb_hit), 0);
        @(posedge clk);
        #1;
        wr_en = 1'b0; req_vld = 1'b0;
        chk(rsp_hit == 1'b0, "R10", "rsp_hit for same-cycle lookup", 32'(rsp_hit), 0);
        chk(cmb_hit == 1'b1, "R10", "cmb_hit after write", 32'(cmb_hit), 1);
        chk(cmb_paddr == 32'h0BEE_F010, "R10", "cmb_paddr after write", cmb_paddr, 32'h0BEE_F010);
        look(32'h0000_A010, 8'h04, 1'b1, 32'h0BEE_F010, 4'b1001, "R10");
    endtask

    task automatic t_idle_r8;
        @(negedge clk);
        req_vld = 1'b0; req_vaddr = 32'h1234_5678; req_pid = 8'h2A;
        #1;
        chk(cmb_hit == 1'b1, "R8", "cmb_hit without strobe", 32'(cmb_hit), 1);
        @(posedge clk);
        #1;
        chk(rsp_vld == 1'b0, "R8", "rsp_vld idle", 32'(rsp_vld), 0);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset_r9();
        t_basic_r3_r6();
        t_global_r3();
        t_valid_ignored_r4();
        t_priority_r5();
        t_wrong_set_r11();
        t_same_cycle_r10();
        t_idle_r8();
        look(32'h0001_6FFF, 8'h00, 1'b1, 32'h0077_7FFF, 4'b1010, "R1");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            #(CLK_PERIOD * 20000);
        join_any
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule